// File: doc/BRIEF.md
# Two-Level Rotating DMA Priority Arbiter

This block picks which of seven DMA channels is served next. It forms two priority groups. The lower group is channels 0 to 3. The upper group is channels 5, 6 and 7 plus one extra slot, and the lower group as a whole fills that slot. Index 4 is not a real requester. It only marks where the lower group sits in the upper order.

Each group has its own mode input that selects fixed or rotating priority, so each level can be set on its own. For every channel, the hardware request line and the software request bit are ORed, so both compete in the same way. When a transfer finishes, the surrounding controller pulses a service-complete strobe along with the channel number. In rotating mode, that strobe moves the serviced position to the bottom of its group.

The grant is one-hot and has a valid flag. It is computed combinationally from the present requests and the stored rotation pointers.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `gnt` is one-hot or zero in every cycle. `gnt_vld` is high exactly when some real channel (0–3 or 5–7) requests. Both follow the request inputs in the same cycle, with no clock edge in between.
- R2: A set bit in `sw_req[c]` is treated exactly like `hw_req[c]`. A channel can be granted with only its software bit set.
- R3: Request bit 4 of either request vector has no effect. Bit 4 of `gnt` is never set, and a request on bit 4 alone leaves `gnt_vld` low.
- R4: With both mode inputs low, the lowest-numbered requesting channel in the order 0,1,2,3,5,6,7 is granted. The lower group always outranks channels 5–7.
- R5: With `lo_rotate` high, a service strobe for channel c in 0–3 makes c the lowest of the lower group. The lower group then searches c+1, c+2, … with wraparound modulo 4.
- R6: With `hi_rotate` high, the upper group's four slots are searched in ring order: lower group, 5, 6, 7. A strobe for 5, 6 or 7 puts that channel last. A strobe for any of channels 0–3 puts the lower-group slot last. The lower group's channels always stay together as one position in this ring.
- R7: The rotation state changes only on a clock edge where `done_vld` is high. Repeated identical requests with no strobe give identical grants.
- R8: A service strobe has no effect on a group whose mode input is low during that edge. The group's stored order is unchanged when it is later switched to rotating mode.
- R9: Reset (active-low `rst_n`, asynchronous) sets both rotation pointers to the top. Channel 0 and the lower-group slot are then highest, so the rotating order right after reset equals the fixed order.
- R10: A service strobe with `done_chan` = 4 changes neither rotation pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 8 | Hardware request per channel index (bit 4 unused) |
| sw_req | input | 8 | Software request per channel index (bit 4 unused) |
| lo_rotate | input | 1 | Lower group (0–3): 1 = rotating, 0 = fixed |
| hi_rotate | input | 1 | Upper group (5–7 plus lower slot): 1 = rotating, 0 = fixed |
| done_vld | input | 1 | Service-complete strobe |
| done_chan | input | 3 | Channel number of the finished service |
| gnt | output | 8 | One-hot grant by channel index |
| gnt_vld | output | 1 | A grant is present |

## Verification
The grant and its valid flag are combinational, so they are due in the same cycle the requests are applied. The bench drives each vector just after a falling edge and samples a moment later, before the next rising edge. A service strobe takes effect only at the following rising edge. Its consequence is therefore checked on the next vector, one cycle later, and each table row lists the grant expected from the pointers left by the row before. For reset, the outputs are checked while `rst_n` is low and again in the first cycle after release.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int GRP_SLOTS  = 4;
  localparam int PTR_W      = $clog2(GRP_SLOTS);
  localparam int CASCADE_CH = 4;

  typedef logic [GRP_SLOTS-1:0] slot_vec_t;
  typedef logic [PTR_W-1:0]     slot_idx_t;
  typedef logic [CH_W-1:0]      ch_idx_t;
  typedef logic [NUM_CH-1:0]    ch_vec_t;

  localparam ch_idx_t CASCADE_IDX = ch_idx_t'(CASCADE_CH);

  // Search the ring starting at slot 'top'; first requester wins.
  function automatic slot_vec_t rot_pick(slot_vec_t req, slot_idx_t top);
    slot_vec_t g;
    logic      hit;
    slot_idx_t idx;
    g   = '0;
    hit = 1'b0;
    for (int k = 0; k < GRP_SLOTS; k++) begin
      idx = top + slot_idx_t'(k);
      if (!hit && req[idx]) begin
        g[idx] = 1'b1;
        hit    = 1'b1;
      end
    end
    return g;
  endfunction

  // The slot after the serviced one becomes the new top of the ring.
  function automatic slot_idx_t next_top(slot_idx_t served);
    return served + slot_idx_t'(1);
  endfunction
endpackage

// File: rtl/dma_arb_group.sv
module dma_arb_group
  import dma_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slot_vec_t req,
  input  logic      rotate,
  input  logic      upd_en,
  input  slot_idx_t upd_slot,
  output slot_vec_t gnt,
  output logic      any,
  output slot_idx_t top_q
);
  slot_idx_t top_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      top_q <= '0;
    else if (upd_en && rotate)
      top_q <= next_top(upd_slot);
  end

  // Fixed mode always searches from slot 0; the stored pointer is kept.
  assign top_eff = rotate ? top_q : '0;
  assign gnt     = rot_pick(req, top_eff);
  assign any     = |req;
endmodule

// File: rtl/dma_arb_done_dec.sv
module dma_arb_done_dec
  import dma_arb_pkg::*;
(
  input  logic      done_vld,
  input  ch_idx_t   done_chan,
  output logic      lo_upd,
  output slot_idx_t lo_slot,
  output logic      hi_upd,
  output slot_idx_t hi_slot
);
  logic is_lo;
  logic is_cascade;

  assign is_lo      = done_chan < CASCADE_IDX;
  assign is_cascade = done_chan == CASCADE_IDX;

  assign lo_upd  = done_vld && is_lo;
  assign lo_slot = done_chan[PTR_W-1:0];
  // Any lower-group channel maps to upper slot 0 (the cascade slot).
  assign hi_upd  = done_vld && !is_cascade;
  assign hi_slot = is_lo ? '0 : slot_idx_t'(done_chan - CASCADE_IDX);
endmodule

// File: rtl/dma_arb_merge.sv
module dma_arb_merge
  import dma_arb_pkg::*;
(
  input  slot_vec_t lo_gnt,
  input  slot_vec_t hi_gnt,
  output ch_vec_t   gnt
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch < CASCADE_CH) begin : g_lo
      assign gnt[ch] = lo_gnt[ch] & hi_gnt[0];
    end else if (ch == CASCADE_CH) begin : g_casc
      assign gnt[ch] = 1'b0;
    end else begin : g_hi
      assign gnt[ch] = hi_gnt[ch-CASCADE_CH];
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic              lo_rotate,
  input  logic              hi_rotate,
  input  logic              done_vld,
  input  logic [CH_W-1:0]   done_chan,
  output logic [NUM_CH-1:0] gnt,
  output logic              gnt_vld
);
  ch_vec_t   req_all;
  slot_vec_t lo_req, hi_req;
  slot_vec_t lo_gnt, hi_gnt;
  logic      lo_any, hi_any;
  slot_idx_t lo_top, hi_top;
  logic      lo_upd, hi_upd;
  slot_idx_t lo_slot, hi_slot;
  logic      cascade_req;

  assign req_all     = hw_req | sw_req;
  assign cascade_req = req_all[CASCADE_CH];

  for (genvar s = 0; s < GRP_SLOTS; s++) begin : g_split
    assign lo_req[s] = req_all[s];
    if (s == 0) begin : g_casc
      assign hi_req[s] = lo_any;
    end else begin : g_up
      assign hi_req[s] = req_all[CASCADE_CH+s];
    end
  end

  dma_arb_done_dec u_dec (
    .done_vld  (done_vld),
    .done_chan (done_chan),
    .lo_upd    (lo_upd),
    .lo_slot   (lo_slot),
    .hi_upd    (hi_upd),
    .hi_slot   (hi_slot)
  );

  dma_arb_group u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (lo_req),
    .rotate   (lo_rotate),
    .upd_en   (lo_upd),
    .upd_slot (lo_slot),
    .gnt      (lo_gnt),
    .any      (lo_any),
    .top_q    (lo_top)
  );

  dma_arb_group u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (hi_req),
    .rotate   (hi_rotate),
    .upd_en   (hi_upd),
    .upd_slot (hi_slot),
    .gnt      (hi_gnt),
    .any      (hi_any),
    .top_q    (hi_top)
  );

  dma_arb_merge u_merge (
    .lo_gnt (lo_gnt),
    .hi_gnt (hi_gnt),
    .gnt    (gnt)
  );

  assign gnt_vld = hi_any;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hw_req,
  input logic [NUM_CH-1:0] sw_req,
  input logic              lo_rotate,
  input logic              hi_rotate,
  input logic              done_vld,
  input logic [CH_W-1:0]   done_chan,
  input logic [NUM_CH-1:0] gnt,
  input logic              gnt_vld,
  input logic              cascade_req,
  input logic [PTR_W-1:0]  lo_top,
  input logic [PTR_W-1:0]  hi_top
);
  localparam logic [NUM_CH-1:0] REAL_MASK = ~(NUM_CH'(1) << CASCADE_CH);

  logic [NUM_CH-1:0] real_req;
  logic [NUM_CH-1:0] lowest_req;
  assign real_req   = (hw_req | sw_req) & REAL_MASK;
  assign lowest_req = real_req & (~real_req + NUM_CH'(1));

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R1
  gnt_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld == (real_req != '0));

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~(hw_req | sw_req)) == '0);

  // R3
  cascade_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt[CASCADE_CH]);

  // R3
  cascade_alone_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_req && real_req == '0) |-> !gnt_vld);

  // R4
  fixed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rotate && !hi_rotate) |-> gnt == lowest_req);

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_vld |=> ($stable(lo_top) && $stable(hi_top)));

  // R8
  lo_fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rotate |=> $stable(lo_top));

  // R8
  hi_fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rotate |=> $stable(hi_top));

  // R10
  cascade_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_chan == CASCADE_IDX) |=> ($stable(lo_top) && $stable(hi_top)));
endmodule

bind dma_prio_arbiter dma_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_req      (hw_req),
  .sw_req      (sw_req),
  .lo_rotate   (lo_rotate),
  .hi_rotate   (hi_rotate),
  .done_vld    (done_vld),
  .done_chan   (done_chan),
  .gnt         (gnt),
  .gnt_vld     (gnt_vld),
  .cascade_req (cascade_req),
  .lo_top      (lo_top),
  .hi_top      (hi_top)
);

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
  localparam int CLK_P  = 10;
  localparam int N_VEC  = 28;
  localparam int WDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hw_req, sw_req;
  logic       lo_rotate, hi_rotate;
  logic       done_vld;
  logic [2:0] done_chan;
  logic [7:0] gnt;
  logic       gnt_vld;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_prio_arbiter u_dma_prio_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_req    (hw_req),
    .sw_req    (sw_req),
    .lo_rotate (lo_rotate),
    .hi_rotate (hi_rotate),
    .done_vld  (done_vld),
    .done_chan (done_chan),
    .gnt       (gnt),
    .gnt_vld   (gnt_vld)
  );

  // {req_tag, lo_rot, hi_rot, hw, sw, done_vld, done_chan, expected gnt}
  // Each row's expected grant uses pointers left by the previous row's strobe.
  localparam logic [33:0] TBL [0:N_VEC-1] = '{
    {4'd4, 1'b0, 1'b0, 8'hEF, 8'h00, 1'b0, 3'd0, 8'h01}, // R4
    {4'd4, 1'b0, 1'b0, 8'hEE, 8'h00, 1'b0, 3'd0, 8'h02}, // R4
    {4'd4, 1'b0, 1'b0, 8'hEC, 8'h00, 1'b0, 3'd0, 8'h04}, // R4
    {4'd4, 1'b0, 1'b0, 8'hE8, 8'h00, 1'b0, 3'd0, 8'h08}, // R4 lower group over 5-7
    {4'd4, 1'b0, 1'b0, 8'hE0, 8'h00, 1'b0, 3'd0, 8'h20}, // R4
    {4'd4, 1'b0, 1'b0, 8'hC0, 8'h00, 1'b0, 3'd0, 8'h40}, // R4
    {4'd4, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 3'd0, 8'h80}, // R4
    {4'd2, 1'b0, 1'b0, 8'hE0, 8'h08, 1'b0, 3'd0, 8'h08}, // R2
    {4'd2, 1'b0, 1'b0, 8'h00, 8'h60, 1'b0, 3'd0, 8'h20}, // R2
    {4'd3, 1'b0, 1'b0, 8'h10, 8'h00, 1'b0, 3'd0, 8'h00}, // R3
    {4'd3, 1'b0, 1'b0, 8'h00, 8'h10, 1'b0, 3'd0, 8'h00}, // R3
    {4'd3, 1'b0, 1'b0, 8'h10, 8'h80, 1'b0, 3'd0, 8'h80}, // R3
    {4'd5, 1'b1, 1'b0, 8'h0F, 8'h00, 1'b1, 3'd0, 8'h01}, // R5 serve 0
    {4'd5, 1'b1, 1'b0, 8'h0F, 8'h00, 1'b0, 3'd0, 8'h02}, // R5
    {4'd5, 1'b1, 1'b0, 8'h0F, 8'h00, 1'b1, 3'd2, 8'h02}, // R5 serve 2
    {4'd5, 1'b1, 1'b0, 8'h0F, 8'h00, 1'b0, 3'd0, 8'h08}, // R5
    {4'd5, 1'b1, 1'b0, 8'h03, 8'h00, 1'b0, 3'd0, 8'h01}, // R5 wrap
    {4'd10,1'b1, 1'b0, 8'hE6, 8'h00, 1'b1, 3'd4, 8'h02}, // R10 strobe 4
    {4'd10,1'b1, 1'b0, 8'hE6, 8'h00, 1'b0, 3'd0, 8'h02}, // R10
    {4'd6, 1'b0, 1'b1, 8'hE1, 8'h00, 1'b1, 3'd5, 8'h01}, // R6 serve 5
    {4'd6, 1'b0, 1'b1, 8'hE1, 8'h00, 1'b0, 3'd0, 8'h40}, // R6
    {4'd8, 1'b0, 1'b1, 8'h21, 8'h00, 1'b1, 3'd1, 8'h01}, // R8 lower fixed
    {4'd6, 1'b0, 1'b1, 8'hE3, 8'h00, 1'b0, 3'd0, 8'h20}, // R6 lower slot last
    {4'd8, 1'b1, 1'b1, 8'h06, 8'h00, 1'b0, 3'd0, 8'h02}, // R8
    {4'd7, 1'b1, 1'b1, 8'h06, 8'h00, 1'b0, 3'd0, 8'h02}, // R7
    {4'd7, 1'b1, 1'b1, 8'hE0, 8'h00, 1'b0, 3'd0, 8'h20}, // R7
    {4'd6, 1'b1, 1'b1, 8'hE0, 8'h00, 1'b1, 3'd7, 8'h20}, // R6 serve 7
    {4'd6, 1'b1, 1'b1, 8'hE1, 8'h00, 1'b0, 3'd0, 8'h01}  // R6
  };

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag, logic [7:0] exp);
    check8(tag, gnt, exp);
    checks++;
    if (gnt_vld !== (exp != 8'h00)) begin   // R1 valid flag
      errors++;
      $display("FAIL R1 (%s) vld: actual=%0b expected=%0b", tag, gnt_vld, exp != 8'h00);
    end
  endtask

  task automatic drive(logic lr, logic hr, logic [7:0] h, logic [7:0] s,
                       logic dv, logic [2:0] dc);
    @(negedge clk);
    lo_rotate = lr; hi_rotate = hr; hw_req = h; sw_req = s;
    done_vld = dv; done_chan = dc;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; hw_req = '0; sw_req = '0; lo_rotate = 1'b0; hi_rotate = 1'b0;
    done_vld = 1'b0; done_chan = '0;
    repeat (3) @(negedge clk);
    #1;
    check_out("R9 reset idle", 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      drive(TBL[i][29], TBL[i][28], TBL[i][27:20], TBL[i][19:12],
            TBL[i][11], TBL[i][10:8]);
      check_out($sformatf("R%0d row %0d", TBL[i][33:30], i), TBL[i][7:0]);
    end

    // R5: serve channel 1 from a fresh lower pointer position
    drive(1'b1, 1'b0, 8'h0F, 8'h00, 1'b1, 3'd1);
    drive(1'b1, 1'b0, 8'h0F, 8'h00, 1'b0, 3'd0);
    check_out("R5 after serve 1", 8'h04);

    // R9: reset returns both rings to the top
    drive(1'b1, 1'b1, 8'h0F, 8'h00, 1'b0, 3'd0);
    rst_n = 1'b0;
    #1;
    check_out("R9 in reset", 8'h01);
    drive(1'b1, 1'b1, 8'h0F, 8'h00, 1'b0, 3'd0);
    rst_n = 1'b1;
    #1;
    check_out("R9 after release lower", 8'h01);
    drive(1'b1, 1'b1, 8'hE2, 8'h00, 1'b0, 3'd0);
    check_out("R9 after release upper", 8'h02);
    drive(1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0);
    check_out("R1 idle", 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule